// File: doc/BRIEF.md
# Two-Wire Register Slave

This block is a target device on a two-wire serial bus (clock line plus open-drain data line). An external controller reaches a small bank of 8-bit control registers through it. Both bus lines are oversampled by the local system clock and pass through a synchronizer. Start, repeated start and stop conditions are then decoded from the synchronized samples. The block answers to one 7-bit device address. The lowest bit of that address comes from a strap input, so two copies can share a bus.

A write transfer carries the device address, a register pointer byte and then any number of data bytes. The data bytes land at consecutive registers, and the pointer stops advancing at the last register, 0x2E. A read transfer starts at the pointer left by an earlier write and streams consecutive registers out, saturating in the same way. The usual way to read is to write the pointer, issue a repeated start, and then read. The data line is driven only low, through an output-enable. The paired data output is tied to zero.

Top module: `twi_regbank_slave`

## Requirements
- R1: After reset the data-line enable is low and every register reads back as 0x00.
- R2: The block acknowledges address byte 0x98/0x99 (device 0x4C) when the strap is 0 and 0x9A/0x9B (device 0x4D) when the strap is 1. To acknowledge, it pulls the data line low for the whole 9th clock pulse. It leaves the line released for the other address.
- R3: After a device address that does not match, the block drives nothing and changes no register until the next start or stop. Bit 0 of the address byte selects direction: 1 means read, 0 means write.
- R4: In a write, the byte after the address byte is the register pointer. Each following data byte is stored at the pointer and acknowledged, and the pointer then advances by one.
- R5: The write pointer never goes past 0x2E. Surplus data bytes are acknowledged and all overwrite register 0x2E.
- R6: A pointer byte above 0x2E gets no acknowledge, and the data bytes that follow are neither acknowledged nor stored. A pointer of exactly 0x2E is accepted.
- R7: A read sends registers MSB first, starting at the current pointer, and advances the pointer after each byte.
- R8: The read pointer also saturates at 0x2E, so reads past it repeat register 0x2E.
- R9: When the controller does not acknowledge a read byte, the block releases the data line and sends nothing more until the next start or stop.
- R10: A repeated start at any point restarts address-byte reception. Pointer and direction can then be changed without a stop.
- R11: A stop at any point, including mid-byte, returns the block to idle with the data line released. A partly received byte is discarded.
- R12: The data-line enable changes only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_strap | input | 1 | Selects the lowest device address bit |
| sda_o | output | 1 | Data value for the pad driver, always 0 |
| sda_oe | output | 1 | High to pull the data line low |

## Verification
The state machine is visible only through the data-line enable, so every internal fault has to appear as a wrong bit on the bus. A wrong state or bit count shows up as a misplaced or missing acknowledge within the same byte, or as a read byte shifted by one bit. A wrong pointer shows up only in a later read, one full transfer after the write that corrupted it. For that reason every write sequence is followed by a read-back at the boundary addresses, and silence after a mismatch or a controller NACK is checked by clocking a byte and expecting 0xFF.

// File: rtl/twi_pkg.sv
package twi_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEV,
      ST_REG,
      ST_WDAT,
      ST_ACK,
      ST_RDAT,
      ST_RACK,
      ST_SKIP
   } twi_state_e;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic level,
   output logic rise,
   output logic fall
);
   if (STAGES < 2) begin : g_bad_stages
      $error("twi_line_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;
   logic              last;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= 1'b1;
            else        chain[0] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b1;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last <= 1'b1;
      else        last <= chain[STAGES-1];
   end

   assign level = chain[STAGES-1];
   assign rise  = level & ~last;
   assign fall  = ~level & last;
endmodule

// File: rtl/twi_reg_file.sv
module twi_reg_file #(
   parameter int                        NUM_REGS  = 47,
   parameter logic [twi_pkg::BYTE_W-1:0] RESET_VAL = '0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [twi_pkg::BYTE_W-1:0] wr_addr,
   input  logic [twi_pkg::BYTE_W-1:0] wr_data,
   input  logic [twi_pkg::BYTE_W-1:0] rd_addr,
   output logic [twi_pkg::BYTE_W-1:0] rd_data
);
   import twi_pkg::*;

   localparam int IW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

   if (NUM_REGS < 1 || NUM_REGS > 256) begin : g_bad_depth
      $error("twi_reg_file: NUM_REGS must be 1..256");
   end

   logic [BYTE_W-1:0] mem [NUM_REGS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_REGS; i++) mem[i] <= RESET_VAL;
      end else if (wr_en) begin
         for (int i = 0; i < NUM_REGS; i++) begin
            if (int'(wr_addr) == i) mem[i] <= wr_data;
         end
      end
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (int'(rd_addr) == i) rd_data = mem[i];
      end
   end

   // R5: stores only ever target an existing register
   a_r5_store_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (int'(wr_addr) < NUM_REGS));

   logic unused_iw;
   assign unused_iw = (IW == 0);
endmodule

// File: rtl/twi_slave_fsm.sv
module twi_slave_fsm #(
   parameter logic [5:0]                 DEV_ADDR_HI = 6'b100110,
   parameter logic [twi_pkg::BYTE_W-1:0] REG_LAST    = 8'h2E
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       scl_lvl,
   input  logic                       scl_rise,
   input  logic                       scl_fall,
   input  logic                       sda_lvl,
   input  logic                       sda_rise,
   input  logic                       sda_fall,
   input  logic                       strap,
   input  logic [twi_pkg::BYTE_W-1:0] rd_data,
   output logic [twi_pkg::BYTE_W-1:0] rd_addr,
   output logic                       wr_en,
   output logic [twi_pkg::BYTE_W-1:0] wr_addr,
   output logic [twi_pkg::BYTE_W-1:0] wr_data,
   output logic                       sda_oe
);
   import twi_pkg::*;

   localparam int BCW = $clog2(BYTE_W + 1);
   localparam logic [BCW-1:0] BC_FULL = BCW'(BYTE_W);
   localparam logic [BCW-1:0] BC_LAST = BCW'(BYTE_W - 1);

   twi_state_e        state, ack_nxt;
   logic [BCW-1:0]    bitcnt;
   logic [BYTE_W-1:0] rx_sh, tx_sh, ptr;
   logic              m_ack;

   logic start_det, stop_det, scl_steady_hi, dev_match;

   assign scl_steady_hi = scl_lvl & ~scl_rise;
   assign start_det     = sda_fall & scl_steady_hi;
   assign stop_det      = sda_rise & scl_steady_hi;
   assign dev_match     = (rx_sh[BYTE_W-1:1] == {DEV_ADDR_HI, strap});
   assign rd_addr       = ptr;

   function automatic logic [BYTE_W-1:0] sat_inc(input logic [BYTE_W-1:0] p);
      return (p >= REG_LAST) ? REG_LAST : p + 1'b1;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         ack_nxt <= ST_IDLE;
         bitcnt  <= '0;
         rx_sh   <= '0;
         tx_sh   <= '0;
         ptr     <= '0;
         m_ack   <= 1'b0;
         sda_oe  <= 1'b0;
         wr_en   <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
      end else begin
         wr_en <= 1'b0;
         if (start_det) begin
            state  <= ST_DEV;
            bitcnt <= '0;
            sda_oe <= 1'b0;
         end else if (stop_det) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
         end else begin
            unique case (state)
               ST_DEV, ST_REG, ST_WDAT: begin
                  if (scl_rise && bitcnt != BC_FULL) begin
                     rx_sh  <= {rx_sh[BYTE_W-2:0], sda_lvl};
                     bitcnt <= bitcnt + 1'b1;
                  end else if (scl_fall && bitcnt == BC_FULL) begin
                     if (state == ST_DEV) begin
                        if (dev_match) begin
                           sda_oe  <= 1'b1;
                           state   <= ST_ACK;
                           ack_nxt <= rx_sh[0] ? ST_RDAT : ST_REG;
                        end else begin
                           state <= ST_SKIP;
                        end
                     end else if (state == ST_REG) begin
                        if (rx_sh <= REG_LAST) begin
                           ptr     <= rx_sh;
                           sda_oe  <= 1'b1;
                           state   <= ST_ACK;
                           ack_nxt <= ST_WDAT;
                        end else begin
                           state <= ST_SKIP;
                        end
                     end else begin
                        wr_en   <= 1'b1;
                        wr_addr <= ptr;
                        wr_data <= rx_sh;
                        ptr     <= sat_inc(ptr);
                        sda_oe  <= 1'b1;
                        state   <= ST_ACK;
                        ack_nxt <= ST_WDAT;
                     end
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     bitcnt <= '0;
                     state  <= ack_nxt;
                     if (ack_nxt == ST_RDAT) begin
                        tx_sh  <= rd_data;
                        sda_oe <= ~rd_data[BYTE_W-1];
                     end else begin
                        sda_oe <= 1'b0;
                     end
                  end
               end
               ST_RDAT: begin
                  if (scl_fall) begin
                     if (bitcnt == BC_LAST) begin
                        sda_oe <= 1'b0;
                        ptr    <= sat_inc(ptr);
                        state  <= ST_RACK;
                     end else begin
                        tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
                        sda_oe <= ~tx_sh[BYTE_W-2];
                        bitcnt <= bitcnt + 1'b1;
                     end
                  end
               end
               ST_RACK: begin
                  if (scl_rise) begin
                     m_ack <= ~sda_lvl;
                  end else if (scl_fall) begin
                     if (m_ack) begin
                        tx_sh  <= rd_data;
                        sda_oe <= ~rd_data[BYTE_W-1];
                        bitcnt <= '0;
                        state  <= ST_RDAT;
                     end else begin
                        state <= ST_SKIP;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R12: the line enable holds still while the clock is high
   a_r12_oe_steady_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
      scl_steady_hi |-> $stable(sda_oe));

   // R3: an ignored transfer leaves the line released
   a_r3_skip_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SKIP) |-> !sda_oe);

   // R11: a stop sends the machine to idle with the line released
   a_r11_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (state == ST_IDLE && !sda_oe));

   // R10: any start reopens address reception from bit zero
   a_r10_start_rx: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (state == ST_DEV && bitcnt == '0));

   // R8: the pointer never runs beyond the last register
   a_r8_ptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
      ptr <= REG_LAST);

   // R9: a controller NACK ends the read
   a_r9_nack_end: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RACK && scl_fall && !m_ack && !start_det && !stop_det)
      |=> (state == ST_SKIP && !sda_oe));
endmodule

// File: rtl/twi_regbank_slave.sv
module twi_regbank_slave #(
   parameter int                         SYNC_STAGES = 2,
   parameter logic [5:0]                 DEV_ADDR_HI = 6'b100110,
   parameter logic [twi_pkg::BYTE_W-1:0] REG_LAST    = 8'h2E,
   parameter logic [twi_pkg::BYTE_W-1:0] RESET_VAL   = 8'h00
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   input  logic addr_strap,
   output logic sda_o,
   output logic sda_oe
);
   import twi_pkg::*;

   localparam int NUM_REGS = int'(REG_LAST) + 1;

   if (REG_LAST == '1) begin : g_bad_last
      $error("twi_regbank_slave: REG_LAST must leave room for a rejected pointer");
   end

   logic scl_lvl, scl_rise, scl_fall;
   logic sda_lvl, sda_rise, sda_fall;
   logic              wr_en;
   logic [BYTE_W-1:0] wr_addr, wr_data, rd_addr, rd_data;

   twi_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .din(scl_i),
      .level(scl_lvl), .rise(scl_rise), .fall(scl_fall));

   twi_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .din(sda_i),
      .level(sda_lvl), .rise(sda_rise), .fall(sda_fall));

   twi_slave_fsm #(.DEV_ADDR_HI(DEV_ADDR_HI), .REG_LAST(REG_LAST)) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .scl_lvl(scl_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .sda_lvl(sda_lvl), .sda_rise(sda_rise), .sda_fall(sda_fall),
      .strap(addr_strap),
      .rd_data(rd_data), .rd_addr(rd_addr),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .sda_oe(sda_oe));

   twi_reg_file #(.NUM_REGS(NUM_REGS), .RESET_VAL(RESET_VAL)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data));

   assign sda_o = 1'b0;
endmodule

// File: tb/twi_regbank_slave_test.sv
module twi_regbank_slave_test;
   localparam int Q = 12;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1, strap = 1'b0;
   logic sda_o, sda_oe;
   logic sda_bus;
   assign sda_bus = sda_m & ~sda_oe;

   twi_regbank_slave uut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
      .addr_strap(strap), .sda_o(sda_o), .sda_oe(sda_oe));

   int checks = 0, errors = 0;
   string exp_req[$];
   int    exp_val[$];
   int    obs_val[$];
   int    r12_bad = 0;

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   // monitor: pops observed results against expected items
   initial forever begin
      @(negedge clk);
      while (obs_val.size() > 0 && exp_val.size() > 0) begin
         check(exp_req.pop_front(), obs_val.pop_front(), exp_val.pop_front());
      end
   end

   // R12 watcher on the port: no enable change while the bus clock stays high
   logic scl_q = 1'b1, oe_q = 1'b0;
   always @(negedge clk) begin
      if (rst_n && scl_m && scl_q && sda_oe != oe_q) r12_bad++;
      scl_q <= scl_m;
      oe_q  <= sda_oe;
   end

   task automatic hold();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; hold();
      scl_m = 1'b1; hold();
      sda_m = 1'b0; hold();
      scl_m = 1'b0; hold();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; hold();
      scl_m = 1'b1; hold();
      sda_m = 1'b1; hold();
   endtask

   task automatic clock_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         sda_m = b[i]; hold();
         scl_m = 1'b1; hold(); hold();
         scl_m = 1'b0; hold();
      end
   endtask

   task automatic send(input logic [7:0] b, input string req, input int ack_exp);
      int ack;
      exp_req.push_back(req); exp_val.push_back(ack_exp);
      clock_bits(b, 8);
      sda_m = 1'b1; hold();
      scl_m = 1'b1; hold();
      ack = sda_bus ? 0 : 1;
      hold();
      scl_m = 1'b0; hold();
      obs_val.push_back(ack);
   endtask

   task automatic recv(input string req, input int v_exp, input bit mack);
      logic [7:0] v;
      exp_req.push_back(req); exp_val.push_back(v_exp);
      sda_m = 1'b1;
      for (int i = 0; i < 8; i++) begin
         hold();
         scl_m = 1'b1; hold();
         v = {v[6:0], sda_bus};
         hold();
         scl_m = 1'b0;
      end
      hold();
      sda_m = ~mack; hold();
      scl_m = 1'b1; hold(); hold();
      scl_m = 1'b0; hold();
      sda_m = 1'b1;
      obs_val.push_back(int'(v));
   endtask

   task automatic wr_seq(input logic [6:0] dev, input logic [7:0] base,
                         input logic [7:0] d0, d1, d2, d3, input int n, input string req);
      logic [7:0] d [4];
      d = '{d0, d1, d2, d3};
      bus_start();
      send({dev, 1'b0}, req, 1);
      send(base, req, 1);
      for (int i = 0; i < n; i++) send(d[i], req, 1);
      bus_stop();
   endtask

   task automatic rd_seq(input logic [6:0] dev, input logic [7:0] base,
                         input logic [7:0] e0, e1, e2, e3, input int n, input string req);
      logic [7:0] e [4];
      e = '{e0, e1, e2, e3};
      bus_start();
      send({dev, 1'b0}, req, 1);
      send(base, req, 1);
      bus_start();
      send({dev, 1'b1}, req, 1);
      for (int i = 0; i < n; i++) recv(req, int'(e[i]), i != n - 1);
      bus_stop();
   endtask

   task automatic finish_run();
      repeat (20) @(negedge clk);
      check("R12 enable moved with clock high", r12_bad, 0);
      check("scoreboard leftover", exp_val.size() + obs_val.size(), 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000 - 10) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog actual running expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      check("R1 enable after reset", int'(sda_oe), 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check("R1 enable idle", int'(sda_oe), 0);

      // R1: registers come up as zero
      rd_seq(7'h4C, 8'h00, 8'h00, 0, 0, 0, 1, "R1 reg 00");
      rd_seq(7'h4C, 8'h2E, 8'h00, 0, 0, 0, 1, "R1 reg 2E");

      // R4 write burst, R7 read-back
      wr_seq(7'h4C, 8'h10, 8'hA5, 8'h3C, 8'h7E, 0, 3, "R4 write");
      rd_seq(7'h4C, 8'h10, 8'hA5, 8'h3C, 8'h7E, 0, 3, "R7 read");

      // R3: foreign address ignored, both directions
      bus_start();
      send(8'h9A, "R3 addr nack", 0);
      send(8'h10, "R3 silent", 0);
      send(8'h00, "R3 silent", 0);
      bus_stop();
      bus_start();
      send(8'h9B, "R3 read addr nack", 0);
      recv("R3 no data", 8'hFF, 1'b0);
      bus_stop();
      rd_seq(7'h4C, 8'h10, 8'hA5, 0, 0, 0, 1, "R3 reg kept");

      // R2: strap moves the device address
      strap = 1'b1; hold();
      wr_seq(7'h4D, 8'h20, 8'h11, 0, 0, 0, 1, "R2 strap1 write");
      bus_start();
      send(8'h98, "R2 old addr nack", 0);
      bus_stop();
      rd_seq(7'h4D, 8'h20, 8'h11, 0, 0, 0, 1, "R2 strap1 read");
      strap = 1'b0; hold();

      // R5 write saturation, R8 read saturation
      wr_seq(7'h4C, 8'h2D, 8'h01, 8'h02, 8'h03, 8'h04, 4, "R5 sat write");
      rd_seq(7'h4C, 8'h2C, 8'h00, 8'h01, 8'h04, 8'h04, 4, "R8 sat read");

      // R6: pointer beyond the last register
      bus_start();
      send(8'h98, "R6 addr", 1);
      send(8'h2F, "R6 ptr 2F nack", 0);
      send(8'h55, "R6 data nack", 0);
      bus_stop();
      bus_start();
      send(8'h98, "R6 addr", 1);
      send(8'hFF, "R6 ptr FF nack", 0);
      bus_stop();
      rd_seq(7'h4C, 8'h2E, 8'h04, 0, 0, 0, 1, "R6 reg 2E kept");
      wr_seq(7'h4C, 8'h2E, 8'h99, 0, 0, 0, 1, "R6 ptr 2E accepted");
      rd_seq(7'h4C, 8'h2E, 8'h99, 0, 0, 0, 1, "R6 reg 2E written");

      // R10: repeated starts change pointer and direction
      bus_start();
      send(8'h98, "R10 addr", 1);
      send(8'h05, "R10 ptr", 1);
      send(8'h66, "R10 data", 1);
      bus_start();
      send(8'h98, "R10 addr again", 1);
      send(8'h06, "R10 ptr", 1);
      send(8'h77, "R10 data", 1);
      bus_start();
      send(8'h98, "R10 addr", 1);
      send(8'h05, "R10 ptr", 1);
      bus_start();
      send(8'h99, "R10 read addr", 1);
      recv("R10 read 05", 8'h66, 1'b1);
      recv("R10 read 06", 8'h77, 1'b0);
      bus_stop();

      // R9: controller NACK ends data
      bus_start();
      send(8'h98, "R9 addr", 1);
      send(8'h10, "R9 ptr", 1);
      bus_start();
      send(8'h99, "R9 read addr", 1);
      recv("R9 first byte", 8'hA5, 1'b0);
      recv("R9 silent after nack", 8'hFF, 1'b0);
      check("R9 enable released", int'(sda_oe), 0);
      bus_stop();

      // R11: stop in the middle of a data byte
      bus_start();
      send(8'h98, "R11 addr", 1);
      send(8'h08, "R11 ptr", 1);
      clock_bits(8'hF0, 4);
      bus_stop();
      hold();
      check("R11 enable after stop", int'(sda_oe), 0);
      rd_seq(7'h4C, 8'h08, 8'h00, 0, 0, 0, 1, "R11 partial discarded");

      finish_run();
   end
endmodule